// File: doc/BRIEF.md
# Privileged Control Register File with Write Legalization

This block holds the machine-level and supervisor-level control registers of a processor core and serves a single access port. An access names a 12-bit register address and either reads it, writes it, or does both in the same cycle. Read data and an illegal-access flag are combinational from the current state. A write that is not flagged takes effect at the next rising clock edge.

Every write is legalized field by field. Bits that are reserved or belong to unsupported features keep legal values, so software can write any pattern without corrupting the state. The supervisor status, interrupt-enable and interrupt-pending registers are not separate storage. They are masked windows onto the machine registers. The status register reports a derived dirty summary in its top bit.

The ISA register lets software switch a few extensions off and back on, but never beyond the configured maximum. The cycle, time and retired-instruction counts are produced elsewhere and arrive as inputs. Their user-level read addresses are gated by the current privilege level and by the two counter-enable registers.

Top module: `priv_csr_warl`

## Requirements
- R1: After reset every writable register reads zero, except the ISA register, which reads the parameter `MAX_ISA`. Privilege encoding is 0 = user, 1 = supervisor, 3 = machine.
- R2: Address 0x344 (machine pending) keeps only bits 1 and 5. Address 0x304 (machine enable) keeps only bits 1, 3, 5, 7 and 9. Address 0x303 (interrupt delegation) keeps only bits 1, 5 and 9. Other bits read zero.
- R3: Address 0x302 (exception delegation) keeps only bits 0, 3, 8, 12, 13 and 15.
- R4: The previous-privilege field, bits 12:11 of the machine status register at 0x300, is legalized on write. The value 2 becomes 0; 0, 1 and 3 are kept when supervisor and user support are present. Without user support any value becomes 3.
- R5: Bit 31 of the status read is 1 exactly when bits 14:13 or bits 16:15 are both ones. This applies to reads at 0x300 and at 0x100.
- R6: A write to 0x305 (machine trap vector) clears bit 1. A write to 0x105 (supervisor trap vector) clears bits 1:0.
- R7: In the ISA register at 0x301, only bits 12, 0, 5, 3 and 2 are writable, and only where `MAX_ISA` has them. Writing bit 5 as 0 forces bit 3 to 0. All other bits keep their value.
- R8: A write to 0x100 changes only status bits 1, 5, 8, 14:13, 16:15, 18 and 19. A read of 0x100 returns only those bits plus bit 31.
- R9: 0x104 and 0x144 read the machine enable and pending registers ANDed with the delegation register. A write to 0x104 changes only the delegated enable bits. A write to 0x144 changes only bit 1, and only if bit 1 is delegated.
- R10: User counter addresses 0xC00-0xC1F (low halves) and 0xC80-0xC9F (high halves) index counter i = addr[4:0], where 0 is cycle, 1 is time and 2 is retired instructions. Access is legal in machine mode. In supervisor mode it needs bit i of 0x306. In user mode it needs bit i of both 0x306 and 0x106. Otherwise the access is illegal.
- R11: Performance counters 3-31 read zero at 0xC03-0xC1F, 0xC83-0xC9F, 0xB03-0xB1F and 0xB83-0xB9F. Event selectors read zero at 0x323-0x33F. 0xF11, 0xF12 and 0xF13 read zero. 0xF14 reads `HART_ID`.
- R12: An access is illegal, and changes no state, in any of these cases: the address is unimplemented; the current privilege is below addr[9:8]; or it writes an address whose bits 11:10 are 11. Read data is zero when an access is illegal.
- R13: Read data reflects the state before a same-cycle write. A legal write is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_lvl | input | 2 | Current privilege level |
| csr_addr | input | 12 | Register address |
| csr_re | input | 1 | Read strobe |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| cycle_cnt | input | 64 | Cycle count from the core |
| time_cnt | input | 64 | Wall-clock count |
| instret_cnt | input | 64 | Retired-instruction count |
| csr_rdata | output | 32 | Read data, combinational |
| csr_illegal | output | 1 | Access is illegal, combinational |

## Verification
A bit that escapes its writable mask, or a status field left in an illegal state, shows on the very next read of that address or of its supervisor alias. The window is one cycle after the offending write. A wrong delegation mask also shows up as wrong alias data for the supervisor enable and pending views. A faulty counter gate shows in the same cycle as a flipped illegal flag on a user counter address. An illegal write that still updates state is exposed only by a later legal read of the register it targeted. The bench therefore reads back right after each rejected write.

// File: rtl/priv_csr_pkg.sv
package priv_csr_pkg;

  localparam int XLEN   = 32;
  localparam int ADDR_W = 12;
  localparam int CTR_W  = 64;
  localparam int IDX_W  = 5;
  localparam int NCTR   = 1 << IDX_W;

  typedef logic [XLEN-1:0] word_t;

  localparam logic [1:0] PL_U = 2'd0;
  localparam logic [1:0] PL_S = 2'd1;
  localparam logic [1:0] PL_H = 2'd2;
  localparam logic [1:0] PL_M = 2'd3;

  localparam int ISA_S = 18;
  localparam int ISA_U = 20;
  localparam int ISA_F = 5;
  localparam int ISA_D = 3;
  localparam int ST_SPP = 8;
  localparam int ST_SD  = XLEN - 1;

  // status: SIE MIE SPIE MPIE FS XS MPRV SUM MXR TVM TW TSR
  localparam word_t STAT_WMASK  = 32'h007F_E0AA;
  localparam word_t SVIEW_MASK  = 32'h000D_E122;
  localparam word_t SD_MASK     = word_t'(1) << ST_SD;
  localparam word_t PEND_WMASK  = 32'h0000_0022;
  localparam word_t ENA_WMASK   = 32'h0000_02AA;
  localparam word_t IDEL_WMASK  = 32'h0000_0222;
  localparam word_t EDEL_WMASK  = 32'h0000_B109;
  localparam word_t ISA_WMASK   = 32'h0000_102D;
  localparam word_t SSOFT_MASK  = 32'h0000_0002;

  typedef enum logic [4:0] {
    R_NONE, R_SSTATUS, R_SIE, R_STVEC, R_SCOUNTEREN, R_SSCRATCH, R_SEPC,
    R_SCAUSE, R_STVAL, R_SIP, R_MSTATUS, R_MISA, R_MEDELEG, R_MIDELEG,
    R_MIE, R_MTVEC, R_MCOUNTEREN, R_MSCRATCH, R_MEPC, R_MCAUSE, R_MTVAL,
    R_MIP, R_ZERO, R_HARTID, R_UCTR, R_MCTR
  } reg_id_t;

  typedef struct packed {
    word_t mstatus;
    word_t misa;
    word_t medeleg;
    word_t mideleg;
    word_t mie;
    word_t mip;
    word_t mtvec;
    word_t stvec;
    word_t mcounteren;
    word_t scounteren;
    word_t mscratch;
    word_t sscratch;
    word_t mepc;
    word_t sepc;
    word_t mcause;
    word_t scause;
    word_t mtval;
    word_t stval;
  } csr_state_t;

  function automatic word_t merge_masked(input word_t old, input word_t val,
                                         input word_t mask);
    return (old & ~mask) | (val & mask);
  endfunction

  function automatic logic [1:0] legal_priv(input logic [1:0] req,
                                            input word_t isa);
    if (!isa[ISA_U]) return PL_M;
    if (req == PL_H || !isa[ISA_S]) return PL_U;
    return req;
  endfunction

  function automatic word_t status_write(input word_t old, input word_t val,
                                         input word_t isa);
    word_t m;
    word_t n;
    m = STAT_WMASK;
    if (isa[ISA_S]) m[ST_SPP] = 1'b1;
    n = merge_masked(old, val, m);
    n[12:11] = legal_priv(val[12:11], isa);
    n[ST_SD] = 1'b0;
    return n;
  endfunction

  function automatic word_t status_read(input word_t s);
    word_t r;
    r = s;
    r[ST_SD] = (&s[14:13]) | (&s[16:15]);
    return r;
  endfunction

  function automatic word_t isa_write(input word_t old, input word_t val,
                                      input word_t max_isa);
    word_t v;
    v = val;
    if (!v[ISA_F]) v[ISA_D] = 1'b0;
    return merge_masked(old, v, ISA_WMASK & max_isa);
  endfunction

  function automatic word_t ctr_pick(input logic [IDX_W-1:0] idx, input logic hi,
                                     input logic [CTR_W-1:0] cyc,
                                     input logic [CTR_W-1:0] tim,
                                     input logic [CTR_W-1:0] ins);
    logic [CTR_W-1:0] c;
    case (idx)
      5'd0:    c = cyc;
      5'd1:    c = tim;
      5'd2:    c = ins;
      default: c = '0;
    endcase
    return hi ? c[CTR_W-1:XLEN] : c[XLEN-1:0];
  endfunction

endpackage

// File: rtl/priv_csr_decode.sv
module priv_csr_decode
  import priv_csr_pkg::*;
#(
  parameter logic [31:0] MAX_ISA = 32'h4014_112D
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_id_t           id,
  output logic [IDX_W-1:0]  ctr_idx,
  output logic              ctr_hi
);
  localparam bit HAS_S = MAX_ISA[ISA_S];

  logic [6:0] grp;
  assign grp     = addr[ADDR_W-1:IDX_W];
  assign ctr_idx = addr[IDX_W-1:0];
  assign ctr_hi  = addr[7];

  always_comb begin
    id = R_NONE;
    case (addr)
      12'h100: id = HAS_S ? R_SSTATUS    : R_NONE;
      12'h104: id = HAS_S ? R_SIE        : R_NONE;
      12'h105: id = HAS_S ? R_STVEC      : R_NONE;
      12'h106: id = HAS_S ? R_SCOUNTEREN : R_NONE;
      12'h140: id = HAS_S ? R_SSCRATCH   : R_NONE;
      12'h141: id = HAS_S ? R_SEPC       : R_NONE;
      12'h142: id = HAS_S ? R_SCAUSE     : R_NONE;
      12'h143: id = HAS_S ? R_STVAL      : R_NONE;
      12'h144: id = HAS_S ? R_SIP        : R_NONE;
      12'h300: id = R_MSTATUS;
      12'h301: id = R_MISA;
      12'h302: id = R_MEDELEG;
      12'h303: id = R_MIDELEG;
      12'h304: id = R_MIE;
      12'h305: id = R_MTVEC;
      12'h306: id = R_MCOUNTEREN;
      12'h340: id = R_MSCRATCH;
      12'h341: id = R_MEPC;
      12'h342: id = R_MCAUSE;
      12'h343: id = R_MTVAL;
      12'h344: id = R_MIP;
      12'hF11, 12'hF12, 12'hF13: id = R_ZERO;
      12'hF14: id = R_HARTID;
      default: begin
        if (grp == 7'h60 || grp == 7'h64)
          id = R_UCTR;
        else if (grp == 7'h58 || grp == 7'h5C) begin
          if (ctr_idx == 5'd1)      id = R_NONE;
          else if (ctr_idx >= 5'd3) id = R_ZERO;
          else                      id = R_MCTR;
        end else if (grp == 7'h19 && ctr_idx >= 5'd3)
          id = R_ZERO;
      end
    endcase
  end
endmodule

// File: rtl/priv_csr_ctr_gate.sv
module priv_csr_ctr_gate
  import priv_csr_pkg::*;
(
  input  logic [1:0]       priv_lvl,
  input  logic [IDX_W-1:0] idx,
  input  word_t            m_en,
  input  word_t            s_en,
  output logic             allow
);
  logic [NCTR-1:0] per_ctr;

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    assign per_ctr[i] = (priv_lvl == PL_M) |
                        (m_en[i] & ((priv_lvl == PL_S) | s_en[i]));
  end

  assign allow = per_ctr[idx];
endmodule

// File: rtl/priv_csr_state.sv
module priv_csr_state
  import priv_csr_pkg::*;
#(
  parameter logic [31:0] MAX_ISA = 32'h4014_112D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  reg_id_t    wr_id,
  input  word_t      wdata,
  output csr_state_t st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= '0;
      st.misa <= MAX_ISA;
    end else if (wr_fire) begin
      case (wr_id)
        R_MSTATUS:    st.mstatus <= status_write(st.mstatus, wdata, MAX_ISA);
        R_SSTATUS:    st.mstatus <= status_write(st.mstatus,
                          merge_masked(st.mstatus, wdata, SVIEW_MASK), MAX_ISA);
        R_MISA:       st.misa    <= isa_write(st.misa, wdata, MAX_ISA);
        R_MEDELEG:    st.medeleg <= merge_masked(st.medeleg, wdata, EDEL_WMASK);
        R_MIDELEG:    st.mideleg <= merge_masked(st.mideleg, wdata, IDEL_WMASK);
        R_MIE:        st.mie     <= merge_masked(st.mie, wdata, ENA_WMASK);
        R_SIE:        st.mie     <= merge_masked(st.mie,
                          merge_masked(st.mie, wdata, st.mideleg), ENA_WMASK);
        R_MIP:        st.mip     <= merge_masked(st.mip, wdata, PEND_WMASK);
        R_SIP:        st.mip     <= merge_masked(st.mip, wdata,
                          SSOFT_MASK & st.mideleg);
        R_MTVEC:      st.mtvec   <= wdata & ~word_t'(2);
        R_STVEC:      st.stvec   <= wdata & ~word_t'(3);
        R_MCOUNTEREN: st.mcounteren <= wdata;
        R_SCOUNTEREN: st.scounteren <= wdata;
        R_MSCRATCH:   st.mscratch <= wdata;
        R_SSCRATCH:   st.sscratch <= wdata;
        R_MEPC:       st.mepc    <= wdata;
        R_SEPC:       st.sepc    <= wdata;
        R_MCAUSE:     st.mcause  <= wdata;
        R_SCAUSE:     st.scause  <= wdata;
        R_MTVAL:      st.mtval   <= wdata;
        R_STVAL:      st.stval   <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/priv_csr_warl.sv
module priv_csr_warl
  import priv_csr_pkg::*;
#(
  parameter logic [31:0] MAX_ISA = 32'h4014_112D,
  parameter logic [31:0] HART_ID = 32'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        priv_lvl,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_re,
  input  logic              csr_we,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [CTR_W-1:0]  cycle_cnt,
  input  logic [CTR_W-1:0]  time_cnt,
  input  logic [CTR_W-1:0]  instret_cnt,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal
);
  reg_id_t          id;
  logic [IDX_W-1:0] ctr_idx;
  logic             ctr_hi;
  logic             ctr_ok;
  logic             bad_addr, bad_priv, bad_ro, bad_ctr, reject;
  logic             wr_fire;
  word_t            rd_mux;
  csr_state_t       st;

  priv_csr_decode #(.MAX_ISA(MAX_ISA)) u_dec (
    .addr(csr_addr), .id(id), .ctr_idx(ctr_idx), .ctr_hi(ctr_hi)
  );

  priv_csr_ctr_gate u_gate (
    .priv_lvl(priv_lvl), .idx(ctr_idx),
    .m_en(st.mcounteren), .s_en(st.scounteren), .allow(ctr_ok)
  );

  assign bad_addr = (id == R_NONE);
  assign bad_priv = (priv_lvl < csr_addr[9:8]);
  assign bad_ro   = csr_we & (&csr_addr[11:10]);
  assign bad_ctr  = (id == R_UCTR) & ~ctr_ok;
  assign reject   = bad_addr | bad_priv | bad_ro | bad_ctr;
  assign wr_fire  = csr_we & ~reject;

  priv_csr_state #(.MAX_ISA(MAX_ISA)) u_st (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_id(id),
    .wdata(csr_wdata), .st(st)
  );

  always_comb begin
    case (id)
      R_MSTATUS:    rd_mux = status_read(st.mstatus);
      R_SSTATUS:    rd_mux = status_read(st.mstatus) & (SVIEW_MASK | SD_MASK);
      R_MISA:       rd_mux = st.misa;
      R_MEDELEG:    rd_mux = st.medeleg;
      R_MIDELEG:    rd_mux = st.mideleg;
      R_MIE:        rd_mux = st.mie;
      R_SIE:        rd_mux = st.mie & st.mideleg;
      R_MIP:        rd_mux = st.mip;
      R_SIP:        rd_mux = st.mip & st.mideleg;
      R_MTVEC:      rd_mux = st.mtvec;
      R_STVEC:      rd_mux = st.stvec;
      R_MCOUNTEREN: rd_mux = st.mcounteren;
      R_SCOUNTEREN: rd_mux = st.scounteren;
      R_MSCRATCH:   rd_mux = st.mscratch;
      R_SSCRATCH:   rd_mux = st.sscratch;
      R_MEPC:       rd_mux = st.mepc;
      R_SEPC:       rd_mux = st.sepc;
      R_MCAUSE:     rd_mux = st.mcause;
      R_SCAUSE:     rd_mux = st.scause;
      R_MTVAL:      rd_mux = st.mtval;
      R_STVAL:      rd_mux = st.stval;
      R_HARTID:     rd_mux = HART_ID;
      R_UCTR, R_MCTR:
                    rd_mux = ctr_pick(ctr_idx, ctr_hi, cycle_cnt, time_cnt, instret_cnt);
      default:      rd_mux = '0;
    endcase
  end

  assign csr_illegal = (csr_re | csr_we) & reject;
  assign csr_rdata   = reject ? '0 : rd_mux;
endmodule

// File: rtl/priv_csr_warl_chk.sv
module priv_csr_warl_chk
  import priv_csr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        priv_lvl,
  input logic [ADDR_W-1:0] csr_addr,
  input logic              csr_re,
  input logic              csr_we,
  input logic [XLEN-1:0]   csr_wdata,
  input logic [XLEN-1:0]   csr_rdata,
  input logic              csr_illegal,
  input csr_state_t        st
);
  // R2
  a_r2_pend_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (st.mip & ~PEND_WMASK) == '0);

  // R4
  a_r4_mpp_not_h: assert property (@(posedge clk) disable iff (!rst_n)
    st.mstatus[12:11] != PL_H);

  // R5
  a_r5_sd_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_re && !csr_illegal && csr_addr == 12'h300) |->
      csr_rdata[31] == ((&csr_rdata[14:13]) || (&csr_rdata[16:15])));

  // R6
  a_r6_stvec_align: assert property (@(posedge clk) disable iff (!rst_n)
    st.stvec[1:0] == 2'b00);

  // R7
  a_r7_d_needs_f: assert property (@(posedge clk) disable iff (!rst_n)
    st.misa[ISA_D] |-> st.misa[ISA_F]);

  // R10
  a_r10_user_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_re && priv_lvl == PL_U && csr_addr[11:5] == 7'h60 &&
     !(st.mcounteren[csr_addr[4:0]] && st.scounteren[csr_addr[4:0]])) |-> csr_illegal);

  // R12
  a_r12_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_illegal) |=> $stable(st));

  // R13
  a_r13_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !csr_illegal && csr_addr == 12'h340) |=> st.mscratch == $past(csr_wdata));
endmodule

bind priv_csr_warl priv_csr_warl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .csr_addr(csr_addr),
  .csr_re(csr_re), .csr_we(csr_we), .csr_wdata(csr_wdata),
  .csr_rdata(csr_rdata), .csr_illegal(csr_illegal), .st(st)
);

// File: tb/sim_priv_csr_warl.sv
`timescale 1ns/1ps
module sim_priv_csr_warl;
  localparam logic [31:0] ISA_MAX = 32'h4014_112D;
  localparam logic [31:0] HID     = 32'd5;
  localparam logic [63:0] CYC = 64'h1111_2222_3333_4444;
  localparam logic [63:0] TIM = 64'h5555_6666_7777_8888;
  localparam logic [63:0] INS = 64'h9999_AAAA_BBBB_CCCC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv_lvl = 2'd3;
  logic [11:0] csr_addr = '0;
  logic        csr_re = 1'b0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  int nvec = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  priv_csr_warl #(.MAX_ISA(ISA_MAX), .HART_ID(HID)) u0 (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .csr_addr(csr_addr),
    .csr_re(csr_re), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .cycle_cnt(CYC), .time_cnt(TIM), .instret_cnt(INS),
    .csr_rdata(csr_rdata), .csr_illegal(csr_illegal)
  );

  task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic ill);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    #1 ill = csr_illegal;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic wr_ok(input logic [11:0] a, input logic [31:0] d);
    logic ill;
    wr(a, d, ill);
    if (ill) begin
      nvec++; nbad++;
      $display("FAIL setup write %h got=illegal exp=legal", a);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic ill);
    @(negedge clk);
    csr_addr = a; csr_re = 1'b1;
    #1 d = csr_rdata; ill = csr_illegal;
    csr_re = 1'b0;
  endtask

  // expects legal access with data exp (bit 32 = illegal flag)
  task automatic expect_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d; logic ill;
    rd(a, d, ill);
    check(tag, {ill, d}, {1'b0, exp});
  endtask

  task automatic expect_ill_rd(input string tag, input logic [11:0] a);
    logic [31:0] d; logic ill;
    rd(a, d, ill);
    check(tag, {ill, d}, {1'b1, 32'h0});
  endtask

  task automatic t_r1_reset;
    expect_rd("R1 mstatus", 12'h300, 32'h0);
    expect_rd("R1 misa", 12'h301, ISA_MAX);
    expect_rd("R1 mie", 12'h304, 32'h0);
    expect_rd("R1 mscratch", 12'h340, 32'h0);
    expect_rd("R1 mcounteren", 12'h306, 32'h0);
  endtask

  task automatic t_r2_int_masks;
    wr_ok(12'h344, 32'hFFFF_FFFF); expect_rd("R2 mip", 12'h344, 32'h22);
    wr_ok(12'h304, 32'hFFFF_FFFF); expect_rd("R2 mie", 12'h304, 32'h2AA);
    wr_ok(12'h303, 32'hFFFF_FFFF); expect_rd("R2 mideleg", 12'h303, 32'h222);
    wr_ok(12'h344, 32'h0); expect_rd("R2 mip clear", 12'h344, 32'h0);
  endtask

  task automatic t_r3_exc_deleg;
    wr_ok(12'h302, 32'hFFFF_FFFF); expect_rd("R3 medeleg", 12'h302, 32'hB109);
    wr_ok(12'h302, 32'h0000_4EF6); expect_rd("R3 medeleg none", 12'h302, 32'h0);
  endtask

  task automatic t_r4_mpp;
    wr_ok(12'h300, 32'h1000); expect_rd("R4 mpp h->u", 12'h300, 32'h0);
    wr_ok(12'h300, 32'h1800); expect_rd("R4 mpp m", 12'h300, 32'h1800);
    wr_ok(12'h300, 32'h0800); expect_rd("R4 mpp s", 12'h300, 32'h0800);
  endtask

  task automatic t_r5_sd;
    wr_ok(12'h300, 32'h6000); expect_rd("R5 fs dirty", 12'h300, 32'h8000_6000);
    wr_ok(12'h300, 32'h2000); expect_rd("R5 fs clean", 12'h300, 32'h2000);
    wr_ok(12'h300, 32'h18000); expect_rd("R5 xs dirty", 12'h300, 32'h8001_8000);
    expect_rd("R5 sstatus sd", 12'h100, 32'h8001_8000);
  endtask

  task automatic t_r6_tvec;
    wr_ok(12'h305, 32'hFFFF_FFFF); expect_rd("R6 mtvec", 12'h305, 32'hFFFF_FFFD);
    wr_ok(12'h105, 32'hFFFF_FFFF); expect_rd("R6 stvec", 12'h105, 32'hFFFF_FFFC);
  endtask

  task automatic t_r7_isa;
    wr_ok(12'h301, 32'h0); expect_rd("R7 clear", 12'h301, 32'h4014_0100);
    wr_ok(12'h301, 32'hFFFF_FFFF); expect_rd("R7 restore", 12'h301, ISA_MAX);
    wr_ok(12'h301, 32'h28); expect_rd("R7 f+d", 12'h301, 32'h4014_0128);
    wr_ok(12'h301, 32'h08); expect_rd("R7 d without f", 12'h301, 32'h4014_0100);
    wr_ok(12'h301, ISA_MAX);
  endtask

  task automatic t_r8_sview;
    wr_ok(12'h300, 32'h0);
    wr_ok(12'h100, 32'hFFFF_FFFF);
    expect_rd("R8 m after s write", 12'h300, 32'h800D_E122);
    expect_rd("R8 s view", 12'h100, 32'h800D_E122);
    wr_ok(12'h300, 32'h88);
    expect_rd("R8 s hides m bits", 12'h100, 32'h0);
    expect_rd("R8 m keeps", 12'h300, 32'h88);
  endtask

  task automatic t_r9_alias;
    wr_ok(12'h303, 32'h222); wr_ok(12'h304, 32'h0);
    wr_ok(12'h104, 32'hFFFF_FFFF);
    expect_rd("R9 sie", 12'h104, 32'h222);
    expect_rd("R9 mie via sie", 12'h304, 32'h222);
    wr_ok(12'h303, 32'h20); wr_ok(12'h304, 32'h8);
    wr_ok(12'h104, 32'hFFFF_FFFF);
    expect_rd("R9 mie partial", 12'h304, 32'h28);
    expect_rd("R9 sie partial", 12'h104, 32'h20);
    wr_ok(12'h303, 32'h2); wr_ok(12'h344, 32'h0);
    wr_ok(12'h144, 32'hFFFF_FFFF);
    expect_rd("R9 sip", 12'h144, 32'h2);
    wr_ok(12'h303, 32'h0);
    wr_ok(12'h144, 32'h0);
    expect_rd("R9 mip untouched", 12'h344, 32'h2);
    expect_rd("R9 sip undelegated", 12'h144, 32'h0);
  endtask

  task automatic t_r10_counters;
    priv_lvl = 2'd3;
    expect_rd("R10 cycle lo", 12'hC00, CYC[31:0]);
    expect_rd("R10 cycle hi", 12'hC80, CYC[63:32]);
    expect_rd("R10 time lo", 12'hC01, TIM[31:0]);
    expect_rd("R10 instret hi", 12'hC82, INS[63:32]);
    expect_rd("R10 minstret", 12'hB02, INS[31:0]);
    wr_ok(12'h306, 32'h1); wr_ok(12'h106, 32'h0);
    priv_lvl = 2'd1;
    expect_rd("R10 s allowed", 12'hC00, CYC[31:0]);
    expect_ill_rd("R10 s blocked", 12'hC02);
    priv_lvl = 2'd0;
    expect_ill_rd("R10 u needs s enable", 12'hC00);
    priv_lvl = 2'd3;
    wr_ok(12'h106, 32'h1);
    priv_lvl = 2'd0;
    expect_rd("R10 u allowed", 12'hC00, CYC[31:0]);
    expect_ill_rd("R10 u blocked hi idx", 12'hC81);
    priv_lvl = 2'd3;
  endtask

  task automatic t_r11_zero;
    expect_rd("R11 hpm user", 12'hC05, 32'h0);
    expect_rd("R11 hpm hi", 12'hC9F, 32'h0);
    expect_rd("R11 mhpm", 12'hB10, 32'h0);
    expect_rd("R11 event", 12'h330, 32'h0);
    expect_rd("R11 arch id", 12'hF12, 32'h0);
    expect_rd("R11 hart", 12'hF14, HID);
  endtask

  task automatic t_r12_illegal;
    logic ill;
    wr_ok(12'h340, 32'hA5A5_0001);
    expect_ill_rd("R12 unimpl read", 12'h7C0);
    expect_ill_rd("R12 gap counter", 12'hB01);
    wr(12'h3FF, 32'hFFFF_FFFF, ill); check("R12 unimpl write flag", {32'h0, ill}, 33'h1);
    wr(12'hC00, 32'h0, ill); check("R12 ro write flag", {32'h0, ill}, 33'h1);
    priv_lvl = 2'd1;
    expect_ill_rd("R12 s reads m reg", 12'h300);
    wr(12'h340, 32'h1234_5678, ill); check("R12 s writes m reg", {32'h0, ill}, 33'h1);
    priv_lvl = 2'd3;
    expect_rd("R12 mscratch unchanged", 12'h340, 32'hA5A5_0001);
  endtask

  task automatic t_r13_timing;
    @(negedge clk);
    csr_addr = 12'h340; csr_wdata = 32'hDEAD_BEEF; csr_we = 1'b1; csr_re = 1'b1;
    #1 check("R13 old value same cycle", {csr_illegal, csr_rdata}, {1'b0, 32'hA5A5_0001});
    @(negedge clk);
    csr_we = 1'b0;
    #1 check("R13 new value next cycle", {csr_illegal, csr_rdata}, {1'b0, 32'hDEAD_BEEF});
    csr_re = 1'b0;
  endtask

  initial begin
    #2_000_000;
    nvec++; nbad++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_r1_reset();
    t_r2_int_masks();
    t_r3_exc_deleg();
    t_r4_mpp();
    t_r5_sd();
    t_r6_tvec();
    t_r7_isa();
    t_r8_sview();
    t_r9_alias();
    t_r10_counters();
    t_r11_zero();
    t_r12_illegal();
    t_r13_timing();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule